// File: doc/BRIEF.md
# Sectioned clock register bank

This block holds the byte registers of a real-time clock: two alarm sections, a control section, a live clock section and a single status byte. A host reaches them through a plain byte-serial front end. A command opens a transaction at a start address, or at the kept address pointer, and then moves bytes one after another. A separate time-base port updates the live clock bytes. The current clock bytes are also driven out for that time base and for neighbouring logic.

Sequential access wraps inside the section being accessed rather than running across the map. Opening a read takes a coherent copy of all eight clock bytes, and clock data in that read comes only from the copy. The status byte can be moved only once per transaction. Writes to every section except status are gated by two enable bits held in the status byte.

Top module: `rtc_regbank`

## Requirements
- R1: After reset, the clock byte at 37h and the alarm bytes at 07h and 0Fh read 20h, every other mapped data byte reads 00h, the status byte reads 01h (RTCF set, BAT input low), the pointer is 00h, `txn_active` and `rd_valid` are 0, and `clk_now` shows the clock bytes, with byte i (address 30h+i) at bits [8i+7:8i].
- R2: Addresses 00h–07h (alarm 0), 08h–0Fh (alarm 1), 10h–13h (control), 30h–37h (clock) and 3Fh (status) are mapped. Any other address reads 00h and discards writes, and the pointer moves to the address plus one, modulo 64.
- R3: Each accepted byte moves the pointer to the next address of its section, and from a section's last address it moves to that section's first address. The status section wraps onto 3Fh.
- R4: The first byte of a transaction at 3Fh is accepted. Any further matching byte request while the pointer is 3Fh is not performed: no data, no write, no pointer change, and `txn_active` drops on the next cycle.
- R5: A write to 3Fh needs no enable. It stores data bit 1 as WEL and bit 2 as RWEL. A status read returns BAT (the `bat_in` input) in bit 7, RWEL in bit 2, WEL in bit 1, RTCF in bit 0 and 0 in the other bits.
- R6: Writes to the alarm, control and clock sections take effect only while WEL and RWEL are both 1. Otherwise they are discarded, and the pointer still advances.
- R7: A read command copies the eight live clock bytes, as they stood before that cycle's edge, into a hold buffer. Clock-section bytes of that read come from the buffer, so time-base updates after the copy, including one in the command cycle, are not returned.
- R8: The pointer keeps its value between transactions. A command with `cmd_cur` set starts at the kept pointer and ignores `cmd_addr`.
- R9: `rd_valid` is high, with `rd_data`, in exactly the cycle after each accepted read byte request.
- R10: RTCF is 1 after reset and is cleared by the first enabled host write to the clock section.
- R11: A host write and a time-base update to the same clock byte in the same cycle leave the host value.
- R12: Byte requests with no open transaction, of the wrong direction, or in the same cycle as `cmd_go` or `txn_end` are ignored. `cmd_go` opens a new transaction, and `txn_end` closes the open one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_go | input | 1 | Open a transaction this cycle |
| cmd_rd | input | 1 | Transaction direction, 1 = read |
| cmd_cur | input | 1 | Start at the kept pointer instead of cmd_addr |
| cmd_addr | input | 6 | Start address |
| byte_wr | input | 1 | Write one byte at the pointer |
| byte_din | input | 8 | Write data |
| byte_rd | input | 1 | Read one byte at the pointer |
| txn_end | input | 1 | Close the open transaction |
| tick_we | input | 1 | Time-base update of one clock byte |
| tick_idx | input | 3 | Clock byte index for the update |
| tick_din | input | 8 | Time-base data |
| bat_in | input | 1 | Battery indication reported in status bit 7 |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data |
| txn_active | output | 1 | A transaction is open |
| clk_now | output | 64 | Live clock bytes, byte i at bits [8i+7:8i] |

## Verification
The snapshot taken by a read command and a time-base update can land in the same cycle. The bench drives `cmd_go` for a read and `tick_we` together on one edge. It expects the read to return the old byte while `clk_now` already shows the new one, and it expects a later read to return the new byte. The other collision is a host write and a time-base update to one clock byte on the same edge. The bench judges that one by checking `clk_now` for the host value.

// File: rtl/rtc_bank_pkg.sv
`timescale 1ns/1ps
package rtc_bank_pkg;
  localparam int NSEC = 5;
  // section order: alarm0, alarm1, control, clock, status
  localparam int SEC_BASE [NSEC] = '{0, 8, 16, 48, 63};
  localparam int SEC_SIZE [NSEC] = '{8, 8, 4, 8, 1};
  typedef enum logic [2:0] {
    SEC_AL0  = 3'd0,
    SEC_AL1  = 3'd1,
    SEC_CTL  = 3'd2,
    SEC_CLK  = 3'd3,
    SEC_STAT = 3'd4,
    SEC_NONE = 3'd5
  } sec_e;
  localparam int CLK_BYTES  = 8;
  localparam int CLK_IDX_W  = $clog2(CLK_BYTES);
  localparam int AL_BYTES   = 8;
  localparam int CTL_BYTES  = 4;
  localparam int CFG_BYTES  = 2 * AL_BYTES + CTL_BYTES;
  localparam int STAT_RTCF  = 0;
  localparam int STAT_WEL   = 1;
  localparam int STAT_RWEL  = 2;
  localparam int STAT_BAT   = 7;
  localparam logic [7:0] Y2K_RESET = 8'h20;
endpackage

// File: rtl/rtc_bank_decode.sv
`timescale 1ns/1ps
module rtc_bank_decode
  import rtc_bank_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output sec_e              sec,
  output logic [ADDR_W-1:0] nxt
);
  logic [NSEC-1:0] hit;

  for (genvar s = 0; s < NSEC; s++) begin : g_hit
    assign hit[s] = (int'(addr) >= SEC_BASE[s]) &&
                    (int'(addr) <  SEC_BASE[s] + SEC_SIZE[s]);
  end

  always_comb begin
    sec = SEC_NONE;
    nxt = addr + 1'b1;
    for (int s = 0; s < NSEC; s++) begin
      if (hit[s]) begin
        sec = sec_e'(3'(s));
        if (int'(addr) == SEC_BASE[s] + SEC_SIZE[s] - 1)
          nxt = ADDR_W'(SEC_BASE[s]);
      end
    end
  end
endmodule

// File: rtl/rtc_bank_clock.sv
`timescale 1ns/1ps
module rtc_bank_clock
  import rtc_bank_pkg::*;
#(
  parameter int BYTES  = CLK_BYTES,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(BYTES)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    host_we,
  input  logic [IDX_W-1:0]        host_idx,
  input  logic [DATA_W-1:0]       host_din,
  input  logic                    tick_we,
  input  logic [IDX_W-1:0]        tick_idx,
  input  logic [DATA_W-1:0]       tick_din,
  input  logic                    snap_take,
  output logic [BYTES*DATA_W-1:0] live_flat,
  output logic [BYTES*DATA_W-1:0] snap_flat
);
  for (genvar i = 0; i < BYTES; i++) begin : g_byte
    localparam logic [DATA_W-1:0] RV = (i == BYTES - 1) ? DATA_W'(Y2K_RESET) : '0;
    logic [DATA_W-1:0] live_q;
    logic [DATA_W-1:0] snap_q;

    // host write outranks the time base on the same byte
    always_ff @(posedge clk) begin
      if (rst)
        live_q <= RV;
      else if (host_we && host_idx == IDX_W'(i))
        live_q <= host_din;
      else if (tick_we && tick_idx == IDX_W'(i))
        live_q <= tick_din;
    end

    // copy takes the value held before this edge
    always_ff @(posedge clk) begin
      if (rst)
        snap_q <= RV;
      else if (snap_take)
        snap_q <= live_q;
    end

    assign live_flat[i*DATA_W +: DATA_W] = live_q;
    assign snap_flat[i*DATA_W +: DATA_W] = snap_q;
  end
endmodule

// File: rtl/rtc_bank_cfg.sv
`timescale 1ns/1ps
module rtc_bank_cfg
  import rtc_bank_pkg::*;
#(
  parameter int DEPTH  = CFG_BYTES,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  function automatic logic [DATA_W-1:0] rst_val(input int i);
    if (i == AL_BYTES - 1 || i == 2 * AL_BYTES - 1)
      return DATA_W'(Y2K_RESET);
    return '0;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++)
        mem_q[i] <= rst_val(i);
    end else if (we) begin
      mem_q[idx] <= din;
    end
  end

  // idx stays below DEPTH whenever the result is selected
  assign dout = mem_q[idx];
endmodule

// File: rtl/rtc_regbank.sv
`timescale 1ns/1ps
module rtc_regbank
  import rtc_bank_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cmd_go,
  input  logic                        cmd_rd,
  input  logic                        cmd_cur,
  input  logic [ADDR_W-1:0]           cmd_addr,
  input  logic                        byte_wr,
  input  logic [DATA_W-1:0]           byte_din,
  input  logic                        byte_rd,
  input  logic                        txn_end,
  input  logic                        tick_we,
  input  logic [CLK_IDX_W-1:0]        tick_idx,
  input  logic [DATA_W-1:0]           tick_din,
  input  logic                        bat_in,
  output logic                        rd_valid,
  output logic [DATA_W-1:0]           rd_data,
  output logic                        txn_active,
  output logic [CLK_BYTES*DATA_W-1:0] clk_now
);
  localparam int CFG_IDX_W = $clog2(CFG_BYTES);

  logic              active_q, is_rd_q, first_q;
  logic              wel_q, rwel_q, rtcf_q;
  logic [ADDR_W-1:0] ptr_q;
  sec_e              sec;
  logic [ADDR_W-1:0] nxt_addr;

  logic rd_acc, wr_acc, op, stat_abort, op_take, rd_take;
  logic wr_en, clk_we, cfg_we, stat_we, in_cfg;
  logic [DATA_W-1:0] cfg_dout, stat_byte, rd_mux, snap_byte;
  logic [CLK_BYTES*DATA_W-1:0] snap_flat;

  rtc_bank_decode #(.ADDR_W(ADDR_W)) dec_i (
    .addr (ptr_q),
    .sec  (sec),
    .nxt  (nxt_addr)
  );

  // byte requests only count inside an open transaction of their direction
  assign rd_acc     = active_q &&  is_rd_q && byte_rd && !cmd_go && !txn_end;
  assign wr_acc     = active_q && !is_rd_q && byte_wr && !cmd_go && !txn_end;
  assign op         = rd_acc || wr_acc;
  assign stat_abort = op && (sec == SEC_STAT) && !first_q;
  assign op_take    = op && !stat_abort;
  assign rd_take    = rd_acc && !stat_abort;

  assign wr_en   = wel_q && rwel_q;
  assign in_cfg  = (sec == SEC_AL0) || (sec == SEC_AL1) || (sec == SEC_CTL);
  assign clk_we  = wr_acc && (sec == SEC_CLK) && wr_en;
  assign cfg_we  = wr_acc && in_cfg && wr_en;
  assign stat_we = wr_acc && (sec == SEC_STAT) && first_q;

  // clock base is aligned to 8 bytes and the config sections start at 0
  rtc_bank_clock #(.BYTES(CLK_BYTES), .DATA_W(DATA_W)) clk_i (
    .clk       (clk),
    .rst       (rst),
    .host_we   (clk_we),
    .host_idx  (ptr_q[CLK_IDX_W-1:0]),
    .host_din  (byte_din),
    .tick_we   (tick_we),
    .tick_idx  (tick_idx),
    .tick_din  (tick_din),
    .snap_take (cmd_go && cmd_rd),
    .live_flat (clk_now),
    .snap_flat (snap_flat)
  );

  rtc_bank_cfg #(.DEPTH(CFG_BYTES), .DATA_W(DATA_W)) cfg_i (
    .clk  (clk),
    .rst  (rst),
    .we   (cfg_we),
    .idx  (ptr_q[CFG_IDX_W-1:0]),
    .din  (byte_din),
    .dout (cfg_dout)
  );

  always_comb begin
    stat_byte            = '0;
    stat_byte[STAT_BAT]  = bat_in;
    stat_byte[STAT_RWEL] = rwel_q;
    stat_byte[STAT_WEL]  = wel_q;
    stat_byte[STAT_RTCF] = rtcf_q;
  end

  assign snap_byte = snap_flat[ptr_q[CLK_IDX_W-1:0]*DATA_W +: DATA_W];

  always_comb begin
    case (sec)
      SEC_AL0, SEC_AL1, SEC_CTL: rd_mux = cfg_dout;
      SEC_CLK:                   rd_mux = snap_byte;
      SEC_STAT:                  rd_mux = stat_byte;
      default:                   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      is_rd_q  <= 1'b0;
      first_q  <= 1'b1;
      ptr_q    <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      wel_q    <= 1'b0;
      rwel_q   <= 1'b0;
      rtcf_q   <= 1'b1;
    end else begin
      rd_valid <= rd_take;
      if (rd_take)
        rd_data <= rd_mux;
      if (cmd_go) begin
        active_q <= 1'b1;
        is_rd_q  <= cmd_rd;
        first_q  <= 1'b1;
        if (!cmd_cur)
          ptr_q <= cmd_addr;
      end else if (txn_end || stat_abort) begin
        active_q <= 1'b0;
      end else if (op_take) begin
        ptr_q   <= nxt_addr;
        first_q <= 1'b0;
      end
      if (stat_we) begin
        wel_q  <= byte_din[STAT_WEL];
        rwel_q <= byte_din[STAT_RWEL];
      end
      if (clk_we)
        rtcf_q <= 1'b0;
    end
  end

  assign txn_active = active_q;
endmodule

// File: rtl/rtc_regbank_chk.sv
`timescale 1ns/1ps
module rtc_regbank_chk (
  input logic        clk,
  input logic        rst,
  input logic        cmd_go,
  input logic        cmd_rd,
  input logic        byte_rd,
  input logic        byte_wr,
  input logic        txn_end,
  input logic        tick_we,
  input logic        rd_valid,
  input logic [7:0]  rd_data,
  input logic        txn_active,
  input logic        is_rd,
  input logic        first,
  input logic [5:0]  ptr,
  input logic        wel,
  input logic        rwel,
  input logic [63:0] clk_now,
  input logic [63:0] snap_flat
);
  logic unmapped, req;
  assign unmapped = !((ptr < 6'h14) || (ptr >= 6'h30 && ptr < 6'h38) || (ptr == 6'h3F));
  assign req = txn_active && !cmd_go && !txn_end && (is_rd ? byte_rd : byte_wr);

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(byte_rd)) else $error("rd_valid without request"); // R9

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(unmapped)) |-> (rd_data == 8'h00)) else $error("unmapped data"); // R2

  AST_STATUS_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (req && ptr == 6'h3F && !first) |=> !txn_active) else $error("status continued"); // R4

  AST_GATE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (req && !is_rd && !(wel && rwel) && !tick_we) |=> $stable(clk_now)) else $error("gated write landed"); // R6

  AST_SNAP_TAKE: assert property (@(posedge clk) disable iff (rst)
    (cmd_go && cmd_rd) |=> (snap_flat == $past(clk_now))) else $error("snapshot mismatch"); // R7

  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (txn_active && is_rd && !cmd_go) |=> $stable(snap_flat)) else $error("snapshot moved"); // R7

  AST_CLK_WRAP: assert property (@(posedge clk) disable iff (rst)
    (req && ptr == 6'h37) |=> (ptr == 6'h30)) else $error("clock wrap"); // R3
endmodule

bind rtc_regbank rtc_regbank_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .cmd_go     (cmd_go),
  .cmd_rd     (cmd_rd),
  .byte_rd    (byte_rd),
  .byte_wr    (byte_wr),
  .txn_end    (txn_end),
  .tick_we    (tick_we),
  .rd_valid   (rd_valid),
  .rd_data    (rd_data),
  .txn_active (txn_active),
  .is_rd      (is_rd_q),
  .first      (first_q),
  .ptr        (ptr_q),
  .wel        (wel_q),
  .rwel       (rwel_q),
  .clk_now    (clk_now),
  .snap_flat  (snap_flat)
);

// File: tb/rtc_regbank_tb_top.sv
`timescale 1ns/1ps
module rtc_regbank_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_go = 0, cmd_rd = 0, cmd_cur = 0;
  logic [5:0] cmd_addr = '0;
  logic byte_wr = 0, byte_rd = 0, txn_end = 0, tick_we = 0, bat_in = 0;
  logic [7:0] byte_din = '0, tick_din = '0;
  logic [2:0] tick_idx = '0;
  logic rd_valid, txn_active;
  logic [7:0] rd_data;
  logic [63:0] clk_now;

  always #4 clk = ~clk;

  rtc_regbank dut_i (
    .clk(clk), .rst(rst), .cmd_go(cmd_go), .cmd_rd(cmd_rd), .cmd_cur(cmd_cur),
    .cmd_addr(cmd_addr), .byte_wr(byte_wr), .byte_din(byte_din), .byte_rd(byte_rd),
    .txn_end(txn_end), .tick_we(tick_we), .tick_idx(tick_idx), .tick_din(tick_din),
    .bat_in(bat_in), .rd_valid(rd_valid), .rd_data(rd_data),
    .txn_active(txn_active), .clk_now(clk_now)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference state
  logic [7:0] m [64];
  logic [7:0] msnap [8];
  logic [5:0] mptr;
  bit mact, mrd, mfirst, mwel, mrwel, mrtcf;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int fsec(input logic [5:0] a);
    if (a < 6'd8)  return 0;
    if (a < 6'd16) return 1;
    if (a < 6'd20) return 2;
    if (a >= 6'd48 && a < 6'd56) return 3;
    if (a == 6'd63) return 4;
    return 5;
  endfunction

  function automatic logic [5:0] fnxt(input logic [5:0] a);
    int b, sz;
    case (fsec(a))
      0: begin b = 0;  sz = 8; end
      1: begin b = 8;  sz = 8; end
      2: begin b = 16; sz = 4; end
      3: begin b = 48; sz = 8; end
      4: begin b = 63; sz = 1; end
      default: return a + 6'd1;
    endcase
    if (int'(a) == b + sz - 1) return 6'(b);
    return a + 6'd1;
  endfunction

  function automatic logic [7:0] fexp(input logic [5:0] a);
    case (fsec(a))
      0, 1, 2: return m[a];
      3:       return msnap[a - 6'd48];
      4:       return {bat_in, 4'b0, mrwel, mwel, mrtcf};
      default: return 8'h00;
    endcase
  endfunction

  task automatic go(input bit rd, input bit cur, input logic [5:0] a);
    cmd_go = 1; cmd_rd = rd; cmd_cur = cur; cmd_addr = a;
    @(negedge clk);
    cmd_go = 0;
    mact = 1; mrd = rd; mfirst = 1;
    if (!cur) mptr = a;
    if (rd) for (int i = 0; i < 8; i++) msnap[i] = m[48+i];
  endtask

  task automatic stop();
    txn_end = 1;
    @(negedge clk);
    txn_end = 0;
    mact = 0;
  endtask

  task automatic op_rd(input string req);
    bit ev, ab;
    logic [7:0] e;
    ev = mact && mrd;
    ab = ev && fsec(mptr) == 4 && !mfirst;
    if (ab) ev = 0;
    e = fexp(mptr);
    byte_rd = 1;
    @(negedge clk);
    byte_rd = 0;
    check(req, rd_valid, ev);
    if (ev) check(req, rd_data, e);
    if (ab) mact = 0;
    else if (mact && mrd) begin mptr = fnxt(mptr); mfirst = 0; end
    check(req, txn_active, mact);
  endtask

  task automatic model_wr(input logic [7:0] d);
    int s;
    s = fsec(mptr);
    if (s == 4) begin mwel = d[1]; mrwel = d[2]; end
    else if (s < 4 && mwel && mrwel) begin
      m[mptr] = d;
      if (s == 3) mrtcf = 0;
    end
    mptr = fnxt(mptr);
    mfirst = 0;
  endtask

  task automatic op_wr(input logic [7:0] d, input string req);
    bit ab;
    ab = mact && !mrd && fsec(mptr) == 4 && !mfirst;
    byte_wr = 1; byte_din = d;
    @(negedge clk);
    byte_wr = 0;
    if (ab) mact = 0;
    else if (mact && !mrd) model_wr(d);
    check(req, txn_active, mact);
  endtask

  task automatic tick(input logic [2:0] i, input logic [7:0] d);
    tick_we = 1; tick_idx = i; tick_din = d;
    @(negedge clk);
    tick_we = 0;
    m[48+i] = d;
  endtask

  task automatic chk_now(input string req);
    for (int i = 0; i < 8; i++) check(req, clk_now[8*i +: 8], m[48+i]);
  endtask

  task automatic set_stat(input logic [7:0] d);
    go(0, 0, 6'h3F);
    op_wr(d, "R5");
    stop();
  endtask

  task automatic rd_stat(input string req);
    go(1, 0, 6'h3F);
    op_rd(req);
    stop();
  endtask

  initial begin
    for (int i = 0; i < 64; i++) m[i] = 8'h00;
    m[7] = 8'h20; m[15] = 8'h20; m[55] = 8'h20;
    for (int i = 0; i < 8; i++) msnap[i] = m[48+i];
    mptr = 0; mact = 0; mrd = 0; mfirst = 1; mwel = 0; mrwel = 0; mrtcf = 1;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state at the ports
    check("R1", txn_active, 0);
    check("R1", rd_valid, 0);
    chk_now("R1");
    go(1, 1, 6'h15);
    op_rd("R1");
    stop();

    // R1 / R2 full-map single-byte sweep of reset values
    for (int a = 0; a < 64; a++) begin
      go(1, 0, 6'(a));
      op_rd(fsec(6'(a)) == 5 ? "R2" : "R1");
      stop();
    end
    @(negedge clk);
    check("R9", rd_valid, 0);

    // R6 gating with only one enable set
    set_stat(8'h02);
    go(0, 0, 6'h10); op_wr(8'hAA, "R6"); op_wr(8'hBB, "R6"); stop();
    go(1, 1, 6'h00); op_rd("R6"); stop();
    go(1, 0, 6'h10); op_rd("R6"); op_rd("R6"); stop();
    set_stat(8'h04);
    go(0, 0, 6'h34); op_wr(8'hCC, "R6"); stop();
    chk_now("R6");
    rd_stat("R5");

    // R3 write sweep over the config sections, both enables set
    set_stat(8'h06);
    for (int s = 0; s < 20; s++) begin
      int len;
      len = (s < 16) ? 10 : 6;
      go(0, 0, 6'(s));
      for (int k = 0; k < len; k++) op_wr(8'(s * 29 + k * 7 + 3), "R3");
      stop();
      go(1, 0, 6'(s));
      for (int k = 0; k < len; k++) op_rd("R3");
      stop();
    end
    rd_stat("R10");

    // R3 sweep over clock section, R10 flag clears
    for (int s = 48; s < 56; s++) begin
      go(0, 0, 6'(s));
      for (int k = 0; k < 10; k++) op_wr(8'(s * 13 + k * 5 + 1), "R3");
      stop();
      chk_now("R3");
      go(1, 0, 6'(s));
      for (int k = 0; k < 10; k++) op_rd("R3");
      stop();
    end
    rd_stat("R10");

    // R8 current-address reads after a wrapping read
    go(1, 0, 6'h12);
    for (int k = 0; k < 4; k++) op_rd("R3");
    stop();
    go(1, 1, 6'h00); op_rd("R8"); op_rd("R8"); stop();
    go(1, 0, 6'h32); op_rd("R8"); stop();
    go(1, 1, 6'h3F); op_rd("R8"); stop();

    // R2 discarded writes still move the pointer into the clock section
    go(0, 0, 6'h2E);
    op_wr(8'h91, "R2"); op_wr(8'h92, "R2"); op_wr(8'h93, "R2");
    stop();
    chk_now("R2");
    go(1, 0, 6'h2E); op_rd("R2"); op_rd("R2"); op_rd("R2"); stop();

    // R4 / R5 status single byte
    bat_in = 1;
    go(0, 0, 6'h3F);
    op_wr(8'h06, "R5");
    op_wr(8'h00, "R4");
    check("R4", txn_active, 0);
    rd_stat("R5");
    go(1, 0, 6'h3F); op_rd("R5"); op_rd("R4"); op_rd("R4");
    go(1, 1, 6'h00); op_rd("R8"); stop();

    // R7 snapshot against a later tick
    go(1, 0, 6'h30);
    tick(3'd0, 8'h5A);
    op_rd("R7");
    chk_now("R7");
    stop();
    go(1, 0, 6'h30); op_rd("R7"); stop();

    // R7 tick in the same cycle as the read command
    cmd_go = 1; cmd_rd = 1; cmd_cur = 0; cmd_addr = 6'h31;
    tick_we = 1; tick_idx = 3'd1; tick_din = 8'h77;
    @(negedge clk);
    cmd_go = 0; tick_we = 0;
    mact = 1; mrd = 1; mfirst = 1; mptr = 6'h31;
    for (int i = 0; i < 8; i++) msnap[i] = m[48+i];
    m[49] = 8'h77;
    op_rd("R7");
    chk_now("R7");
    stop();
    go(1, 0, 6'h31); op_rd("R7"); stop();

    // R11 host write versus tick on the same byte
    go(0, 0, 6'h32);
    byte_wr = 1; byte_din = 8'h11;
    tick_we = 1; tick_idx = 3'd2; tick_din = 8'h22;
    @(negedge clk);
    byte_wr = 0; tick_we = 0;
    model_wr(8'h11);
    chk_now("R11");
    stop();

    // R12 ignored requests
    byte_wr = 1; byte_din = 8'h99;
    @(negedge clk);
    byte_wr = 0;
    chk_now("R12");
    op_rd("R12");
    cmd_go = 1; cmd_rd = 0; cmd_cur = 0; cmd_addr = 6'h34;
    byte_wr = 1; byte_din = 8'hEE;
    @(negedge clk);
    cmd_go = 0; byte_wr = 0;
    mact = 1; mrd = 0; mfirst = 1; mptr = 6'h34;
    chk_now("R12");
    op_wr(8'h44, "R12");
    byte_wr = 1; byte_din = 8'h55; txn_end = 1;
    @(negedge clk);
    byte_wr = 0; txn_end = 0;
    mact = 0;
    chk_now("R12");
    go(1, 1, 6'h00); op_rd("R12"); op_rd("R12"); stop();
    go(1, 0, 6'h33); byte_wr = 1; byte_din = 8'h66;
    @(negedge clk);
    byte_wr = 0;
    chk_now("R12");
    op_rd("R12");
    stop();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule